// File: doc/BRIEF.md
# Five-Port Micro-Op Dispatch Arbiter

This block sits between an out-of-order scheduler and five execution ports. Each clock it sees up to three ready micro-ops. Slot 0 holds the oldest and slot 2 the youngest. Each micro-op carries a three-bit operation class. In the same cycle the arbiter decides which ones go out and which port each one takes. A micro-op that is not placed raises a stall flag on its slot, and the scheduler presents it again on the next clock.

Port 0 and port 1 are the two integer/arithmetic ports. Port 2 serves loads, port 3 computes store addresses and port 4 writes store data. Plain ALU work (moves, add, logic) may use either arithmetic port. Every other class is tied to exactly one port. Each port has a busy input from its execution unit, and a busy port takes nothing that cycle. The decisions are registered, and the ports see one issue record each (valid, source slot, class) on the following clock.

Top module: `uop_dispatch_arb`

## Requirements
- R1: Class codes are ALU=0, COMPLEX=1 (multiply/divide/shift/rotate/floating point), BRANCH=2, LOAD=3, STORE_ADDR=4, STORE_DATA=5. COMPLEX issues only on port 0, BRANCH only on port 1, LOAD only on port 2, STORE_ADDR only on port 3 and STORE_DATA only on port 4. Codes 6 and 7 are never granted.
- R2: An ALU micro-op takes port 1 when port 1 is available. It takes port 0 when only port 0 is available. It stalls when neither is available.
- R3: A port issues at most one micro-op per clock. When slots compete for a port, the lower-numbered (older) slot wins.
- R4: A port whose busy input is high in a cycle grants nothing in that cycle.
- R5: In the same cycle, every valid slot is either granted (grant_o bit high) or stalled (stall_o bit high), never both.
- R6: A grant in cycle N appears on the chosen port's port_go_o in cycle N+1, together with the source slot index (2 bits per port at [2p+1:2p]) and the class (3 bits per port at [3p+2:3p]). Ports without an issue show zero slot and class.
- R7: While reset is active, and on the first cycle after it, no port reports an issue.
- R8: A slot whose valid bit is low is never granted or stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uop_valid_i | input | 3 | Ready micro-op present per slot (bit 0 is oldest) |
| uop_cls_i | input | 9 | Class per slot, slot i at [3i+2:3i] |
| port_busy_i | input | 5 | Execution unit busy, one bit per port |
| grant_o | output | 3 | Slot placed on a port this cycle |
| stall_o | output | 3 | Valid slot not placed; it must be presented again |
| port_go_o | output | 5 | Registered issue strobe per port |
| port_slot_o | output | 10 | Registered source slot per port |
| port_cls_o | output | 15 | Registered class per port |

## Verification
The embedded assertions check the following on every cycle. A busy port never issues on the next clock. The number of registered issues equals the number of grants one cycle earlier. Pinned ports carry only their own class. An oldest slot with a free eligible port is always granted, and an ALU micro-op seeing a free port 1 always lands there.

Only the directed scenarios show some of the behaviour. These are the choice of port 0 when port 1 is busy, the ordering between an older ALU micro-op and a younger complex one, the rejection of the undefined class codes, and the exact slot index and class reported on each port.

// File: rtl/uop_dispatch_pkg.sv
package uop_dispatch_pkg;

    localparam int CLS_W      = 3;
    localparam int PORT_COUNT = 5;

    typedef enum logic [CLS_W-1:0] {
        UC_ALU     = 3'd0,
        UC_COMPLEX = 3'd1,
        UC_BRANCH  = 3'd2,
        UC_LOAD    = 3'd3,
        UC_STADDR  = 3'd4,
        UC_STDATA  = 3'd5
    } uop_cls_e;

    localparam int PORT_INT0   = 0;
    localparam int PORT_INT1   = 1;
    localparam int PORT_LOAD   = 2;
    localparam int PORT_STADDR = 3;
    localparam int PORT_STDATA = 4;

endpackage

// File: rtl/uop_class_route.sv
// Turns each slot's class into the set of ports it may legally use.
module uop_class_route
    import uop_dispatch_pkg::*;
#(
    parameter int NUM_SLOTS = 3
) (
    input  logic [NUM_SLOTS*CLS_W-1:0]      cls_i,
    output logic [NUM_SLOTS*PORT_COUNT-1:0] mask_o
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_comb begin
            mask_o[s*PORT_COUNT +: PORT_COUNT] = '0;
            unique case (cls_i[s*CLS_W +: CLS_W])
                UC_ALU: begin
                    mask_o[s*PORT_COUNT + PORT_INT0] = 1'b1;
                    mask_o[s*PORT_COUNT + PORT_INT1] = 1'b1;
                end
                UC_COMPLEX: mask_o[s*PORT_COUNT + PORT_INT0]   = 1'b1;
                UC_BRANCH:  mask_o[s*PORT_COUNT + PORT_INT1]   = 1'b1;
                UC_LOAD:    mask_o[s*PORT_COUNT + PORT_LOAD]   = 1'b1;
                UC_STADDR:  mask_o[s*PORT_COUNT + PORT_STADDR] = 1'b1;
                UC_STDATA:  mask_o[s*PORT_COUNT + PORT_STDATA] = 1'b1;
                default:    mask_o[s*PORT_COUNT +: PORT_COUNT] = '0;
            endcase
        end
    end

endmodule

// File: rtl/uop_port_alloc.sv
// Walks the slots oldest first. Each slot claims the highest-numbered port
// that is eligible, not busy and not yet claimed. The ALU mask {0,1} therefore
// prefers port 1.
module uop_port_alloc
    import uop_dispatch_pkg::*;
#(
    parameter int NUM_SLOTS = 3,
    localparam int PW       = $clog2(PORT_COUNT)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SLOTS-1:0]            valid_i,
    input  logic [NUM_SLOTS*PORT_COUNT-1:0] mask_i,
    input  logic [PORT_COUNT-1:0]           busy_i,
    output logic [NUM_SLOTS-1:0]            grant_o,
    output logic [NUM_SLOTS*PW-1:0]         sel_o
);

    logic [PORT_COUNT-1:0] taken;

    always_comb begin
        taken   = '0;
        grant_o = '0;
        sel_o   = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int p = 0; p < PORT_COUNT; p++) begin
                if (valid_i[s] && mask_i[s*PORT_COUNT+p] && !busy_i[p] && !taken[p]) begin
                    grant_o[s]          = 1'b1;
                    sel_o[s*PW +: PW]   = PW'(p);
                end
            end
            if (grant_o[s]) taken[sel_o[s*PW +: PW]] = 1'b1;
        end
    end

    // The oldest slot is never refused while one of its ports is free.
    assert_oldest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i[0] && ((mask_i[PORT_COUNT-1:0] & ~busy_i) != '0)) |-> grant_o[0]);

    // An ALU op in the oldest slot with port 1 free lands on port 1.
    assert_alu_prefers_int1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i[0] && mask_i[PORT_INT0] && mask_i[PORT_INT1] && !busy_i[PORT_INT1])
        |-> (grant_o[0] && sel_o[PW-1:0] == PW'(PORT_INT1)));

    assert_no_phantom_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~valid_i) == '0);

endmodule

// File: rtl/uop_dispatch_arb.sv
module uop_dispatch_arb
    import uop_dispatch_pkg::*;
#(
    parameter int NUM_SLOTS = 3,
    localparam int SW       = $clog2(NUM_SLOTS),
    localparam int PW       = $clog2(PORT_COUNT)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SLOTS-1:0]            uop_valid_i,
    input  logic [NUM_SLOTS*CLS_W-1:0]      uop_cls_i,
    input  logic [PORT_COUNT-1:0]           port_busy_i,
    output logic [NUM_SLOTS-1:0]            grant_o,
    output logic [NUM_SLOTS-1:0]            stall_o,
    output logic [PORT_COUNT-1:0]           port_go_o,
    output logic [PORT_COUNT*SW-1:0]        port_slot_o,
    output logic [PORT_COUNT*CLS_W-1:0]     port_cls_o
);

    typedef struct packed {
        logic [PORT_COUNT-1:0]       go;
        logic [PORT_COUNT*SW-1:0]    slot;
        logic [PORT_COUNT*CLS_W-1:0] cls;
    } issue_t;

    logic [NUM_SLOTS*PORT_COUNT-1:0] elig_mask;
    logic [NUM_SLOTS*PW-1:0]         slot_sel;
    issue_t                          iss_d, iss_q;

    uop_class_route #(.NUM_SLOTS(NUM_SLOTS)) u_route (
        .cls_i  (uop_cls_i),
        .mask_o (elig_mask)
    );

    uop_port_alloc #(.NUM_SLOTS(NUM_SLOTS)) u_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (uop_valid_i),
        .mask_i  (elig_mask),
        .busy_i  (port_busy_i),
        .grant_o (grant_o),
        .sel_o   (slot_sel)
    );

    assign stall_o = uop_valid_i & ~grant_o;

    always_comb begin
        iss_d = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int p = 0; p < PORT_COUNT; p++) begin
                if (grant_o[s] && slot_sel[s*PW +: PW] == PW'(p)) begin
                    iss_d.go[p]               = 1'b1;
                    iss_d.slot[p*SW +: SW]    = SW'(s);
                    iss_d.cls[p*CLS_W +: CLS_W] = uop_cls_i[s*CLS_W +: CLS_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) iss_q <= '0;
        else        iss_q <= iss_d;
    end

    assign port_go_o   = iss_q.go;
    assign port_slot_o = iss_q.slot;
    assign port_cls_o  = iss_q.cls;

    for (genvar p = 0; p < PORT_COUNT; p++) begin : g_port_chk
        assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
            port_busy_i[p] |=> !port_go_o[p]);
    end

    assert_issue_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(port_go_o) == $past($countones(grant_o))));

    assert_load_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
        port_go_o[PORT_LOAD] |-> port_cls_o[PORT_LOAD*CLS_W +: CLS_W] == UC_LOAD);

    assert_staddr_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
        port_go_o[PORT_STADDR] |-> port_cls_o[PORT_STADDR*CLS_W +: CLS_W] == UC_STADDR);

    assert_stdata_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
        port_go_o[PORT_STDATA] |-> port_cls_o[PORT_STDATA*CLS_W +: CLS_W] == UC_STDATA);

    assert_branch_on_int1_R1: assert property (@(posedge clk) disable iff (!rst_n)
        port_go_o[PORT_INT0] |-> port_cls_o[PORT_INT0*CLS_W +: CLS_W] != UC_BRANCH);

    assert_complex_on_int0_R1: assert property (@(posedge clk) disable iff (!rst_n)
        port_go_o[PORT_INT1] |-> port_cls_o[PORT_INT1*CLS_W +: CLS_W] != UC_COMPLEX);

endmodule

// File: tb/tb_uop_dispatch_arb.sv
module tb_uop_dispatch_arb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  uop_valid_i = '0;
    logic [8:0]  uop_cls_i = '0;
    logic [4:0]  port_busy_i = '0;
    logic [2:0]  grant_o, stall_o;
    logic [4:0]  port_go_o;
    logic [9:0]  port_slot_o;
    logic [14:0] port_cls_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;   // 250 MHz

    uop_dispatch_arb dut (
        .clk(clk), .rst_n(rst_n), .uop_valid_i(uop_valid_i), .uop_cls_i(uop_cls_i),
        .port_busy_i(port_busy_i), .grant_o(grant_o), .stall_o(stall_o),
        .port_go_o(port_go_o), .port_slot_o(port_slot_o), .port_cls_o(port_cls_o)
    );

    localparam logic [2:0] ALU = 3'd0, CPX = 3'd1, BR = 3'd2, LD = 3'd3, SA = 3'd4, SD = 3'd5;

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // One dispatch cycle: drive after a falling edge, check grants, then check
    // the registered issue record after the next rising edge.
    task automatic step(input string req, input logic [2:0] v, input logic [8:0] cls,
                        input logic [4:0] busy, input logic [2:0] eg, input logic [4:0] ego,
                        input logic [9:0] eslot, input logic [14:0] ecls);
        @(negedge clk);
        uop_valid_i = v; uop_cls_i = cls; port_busy_i = busy;
        #1;
        chk(req, "grant", 32'(grant_o), 32'(eg));
        chk("R5", "stall", 32'(stall_o), 32'(v & ~eg));
        @(posedge clk); #1;
        chk(req, "port_go", 32'(port_go_o), 32'(ego));
        chk(req, "port_slot", 32'(port_slot_o), 32'(eslot));
        chk(req, "port_cls", 32'(port_cls_o), 32'(ecls));
    endtask

    task automatic t_reset;
        #1;
        chk("R7", "go in reset", 32'(port_go_o), 32'h0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R7", "go after reset", 32'(port_go_o), 32'h0);
    endtask

    task automatic t_pinned_mem;   // R1
        step("R1", 3'b111, {SD, SA, LD}, 5'b0, 3'b111, 5'b11100,
             {2'd2, 2'd1, 2'd0, 2'd0, 2'd0}, {SD, SA, LD, 3'd0, 3'd0});
    endtask

    task automatic t_pinned_int;   // R1
        step("R1", 3'b111, {LD, BR, CPX}, 5'b0, 3'b111, 5'b00111,
             {2'd0, 2'd0, 2'd2, 2'd1, 2'd0}, {3'd0, 3'd0, LD, BR, CPX});
    endtask

    task automatic t_alu_choice;   // R2
        step("R2", 3'b001, {LD, LD, ALU}, 5'b0, 3'b001, 5'b00010,
             10'd0, {3'd0, 3'd0, 3'd0, ALU, 3'd0});
        step("R2", 3'b111, {ALU, ALU, ALU}, 5'b0, 3'b011, 5'b00011,
             {2'd0, 2'd0, 2'd0, 2'd0, 2'd1}, 15'd0);
        step("R2", 3'b001, {LD, LD, ALU}, 5'b00010, 3'b001, 5'b00001, 10'd0, 15'd0);
        step("R2", 3'b001, {LD, LD, ALU}, 5'b00011, 3'b000, 5'b00000, 10'd0, 15'd0);
    endtask

    task automatic t_conflicts;    // R3
        step("R3", 3'b011, {LD, LD, LD}, 5'b0, 3'b001, 5'b00100,
             10'd0, {3'd0, 3'd0, LD, 3'd0, 3'd0});
        step("R3", 3'b011, {LD, CPX, ALU}, 5'b0, 3'b011, 5'b00011,
             {2'd0, 2'd0, 2'd0, 2'd0, 2'd1}, {3'd0, 3'd0, 3'd0, ALU, CPX});
        step("R3", 3'b011, {LD, ALU, BR}, 5'b0, 3'b011, 5'b00011,
             {2'd0, 2'd0, 2'd0, 2'd0, 2'd1}, {3'd0, 3'd0, 3'd0, BR, ALU});
        // port 1 busy: older ALU falls back to port 0 and shuts out a younger complex op
        step("R3", 3'b011, {LD, CPX, ALU}, 5'b00010, 3'b001, 5'b00001, 10'd0, 15'd0);
    endtask

    task automatic t_busy;         // R4
        step("R4", 3'b111, {SD, SA, LD}, 5'b10100, 3'b010, 5'b01000,
             {2'd0, 2'd1, 2'd0, 2'd0, 2'd0}, {3'd0, SA, 3'd0, 3'd0, 3'd0});
    endtask

    task automatic t_valid_and_codes;   // R8, R1
        step("R8", 3'b010, {LD, BR, LD}, 5'b0, 3'b010, 5'b00010,
             {2'd0, 2'd0, 2'd0, 2'd1, 2'd0}, {3'd0, 3'd0, 3'd0, BR, 3'd0});
        step("R1", 3'b011, {LD, 3'd7, 3'd6}, 5'b0, 3'b000, 5'b00000, 10'd0, 15'd0);
        step("R8", 3'b000, {ALU, ALU, ALU}, 5'b0, 3'b000, 5'b00000, 10'd0, 15'd0);
    endtask

    initial begin
        t_reset();
        t_pinned_mem();
        t_pinned_int();
        t_alu_choice();
        t_conflicts();
        t_busy();
        t_valid_and_codes();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule